// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal request port and an external asynchronous byte-wide static RAM with a 15-bit address, a shared data bus, and three active-low strobes: select, write strobe and output gate. Single-word read and write requests arrive on a valid/ready handshake. The controller turns each one into a strobe sequence and holds every phase for a number of clock cycles set by parameters, so that the RAM's minimum timing is met at the clock period in use.

Reads gate the RAM output onto the bus, capture the byte at the end of the access window, and return it with a one-cycle response pulse. The bus is then left floating for a turnaround period before any new request is accepted. Writes keep the output gate inactive, so the short write pulse is enough. The controller drives the bus only while the write strobe is low and for one recovery cycle after it. The data bus is split into output, output-enable and input vectors, and the pad tristate sits outside the block.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and directly after reset, select, write strobe and output gate are all high (inactive), the bus output enable is 0, the response pulse is 0 and the request port is ready.
- R2: The request port is ready only when the controller is idle, with all strobes high and the bus not driven. A request is taken on a clock edge where valid and ready are both 1. A request presented while an access is in progress has no effect on the strobes or the address of that access.
- R3: A read (request write flag 0) holds select low, output gate low and write strobe high for exactly RD_CYC consecutive cycles, starting in the cycle after acceptance.
- R4: The read byte is the bus input value in the last cycle of the read window. It is returned on the response data with a response pulse that is high for exactly the one cycle following that window.
- R5: After a read window, select and output gate go high and the controller neither drives the bus nor accepts a request for TURN_CYC cycles.
- R6: A write (request write flag 1) holds select low and write strobe low for exactly WR_CYC consecutive cycles, starting in the cycle after acceptance. The output gate stays high throughout.
- R7: The bus output enable is 1 exactly during the write-strobe-low cycles and the one cycle after them. It is never 1 while the output gate is low.
- R8: The RAM address and the driven write data equal the accepted request's values and stay unchanged from the cycle after acceptance until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to be written |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Returned read byte |
| sram_addr | output | ADDR_W | RAM address |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output gate, active low |
| sram_dq_o | output | DATA_W | Bus value driven toward the RAM |
| sram_dq_oe | output | 1 | Bus drive enable for the pad tristate |
| sram_dq_i | input | DATA_W | Bus value seen from the RAM |

## Verification
Two events can fall in the same cycle: the end of one access and a newly arriving request. After a read, the end of the RAM's bus release and a bus drive for a write can also meet. The bench issues reads and writes back to back, including write-after-read and read-after-write to the same address. It sometimes holds a second request on the port during an access. A bus model in the bench marks its own output busy through the float period, flags any cycle where both sides drive, and returns a corrupted byte when a read is sampled before the access time has passed. Every returned byte and every strobe window is compared with values that bench functions derive from a shadow copy of the memory.

// File: rtl/sram_async_ctrl_pkg.sv
package sram_async_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WIN,
        ST_RD_FLOAT,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctrl_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // Phase lengths come from the loaded value (R3, R6)
    assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sram_dq_driver.sv
module sram_dq_driver #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              drive_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    // Zero the outgoing lanes when not driving so the pad sees a quiet value
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign dq_o[b] = drive_en & wdata[b];
    end

    assign dq_oe = drive_en;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture) begin
            cap_d.data = dq_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_rdata = cap_q.data;

    assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_async_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned RD_CYC   = 3,
    parameter int unsigned WR_CYC   = 2,
    parameter int unsigned DSU_CYC  = 2,
    parameter int unsigned TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int unsigned MAX_CYC = max_of(max_of(RD_CYC, WR_CYC), TURN_CYC);
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    if (RD_CYC < 1 || WR_CYC < 1 || DSU_CYC < 1 || TURN_CYC < 1) begin : g_bad_len
        $error("every phase length must be at least one cycle");
    end
    if (DSU_CYC > WR_CYC) begin : g_bad_setup
        $error("data setup cannot exceed the write pulse, data is driven from its start");
    end

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             capture;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.st  = ST_WR_PULSE;
                        tmr_val = WR_LOAD;
                    end else begin
                        r_d.st  = ST_RD_WIN;
                        tmr_val = RD_LOAD;
                    end
                end
            end
            ST_RD_WIN: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    r_d.st   = ST_RD_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end
            end
            ST_RD_FLOAT: begin
                if (tmr_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    r_d.st = ST_WR_RECOV;
                end
            end
            ST_WR_RECOV: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_dq_driver #(
        .DATA_W (DATA_W)
    ) u_dq (
        .drive_en (r_q.st == ST_WR_PULSE || r_q.st == ST_WR_RECOV),
        .wdata    (r_q.wdata),
        .dq_o     (sram_dq_o),
        .dq_oe    (sram_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .dq_i      (sram_dq_i),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign sram_addr = r_q.addr;
    assign sram_cs_n = !(r_q.st == ST_RD_WIN || r_q.st == ST_WR_PULSE);
    assign sram_we_n = (r_q.st != ST_WR_PULSE);
    assign sram_oe_n = (r_q.st != ST_RD_WIN);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    assert_gate_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_oe_n && !sram_cs_n));

    assert_no_drive_with_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_strobe_drives_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_dq_oe);

    assert_float_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (!sram_dq_oe && !req_ready && sram_cs_n));

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(sram_addr) && $stable(sram_dq_o)));

    assert_rsp_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $fell(sram_oe_n) == 1'b0 && $past(!sram_oe_n));

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

    localparam int unsigned AW   = 15;
    localparam int unsigned DW   = 8;
    localparam int unsigned RD   = 3;
    localparam int unsigned WR   = 2;
    localparam int unsigned DSU  = 2;
    localparam int unsigned TURN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_oe_n;
    logic [DW-1:0] sram_dq_o;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_i = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .RD_CYC (RD),
        .WR_CYC (WR), .DSU_CYC (DSU), .TURN_CYC (TURN)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .sram_addr (sram_addr), .sram_cs_n (sram_cs_n), .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n), .sram_dq_o (sram_dq_o), .sram_dq_oe (sram_dq_oe),
        .sram_dq_i (sram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] init_byte(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5C;
    endfunction

    // Shadow copy used for expected values
    logic [DW-1:0] shadow [int];
    function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return init_byte(a);
    endfunction

    // Behavioural RAM with access-time, float and pulse-width checks
    logic [DW-1:0] ram [int];
    function automatic logic [DW-1:0] ram_rd(input logic [AW-1:0] a);
        if (ram.exists(int'(a))) return ram[int'(a)];
        return init_byte(a);
    endfunction

    int            rd_cnt = 0;
    bit            rd_prev = 1'b0;
    logic [AW-1:0] rd_prev_addr = '0;
    int            float_cnt = 0;
    int            wr_cnt = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;

    always @(negedge clk) begin
        bit rd_act, wr_act, ram_drive;
        if (rst_n) begin
            rd_act = !sram_cs_n && !sram_oe_n && sram_we_n;
            wr_act = !sram_cs_n && !sram_we_n;
            ram_drive = rd_act || (float_cnt > 0);
            if (sram_dq_oe || ram_drive)
                chk(!(sram_dq_oe && ram_drive), "R7 bus contention", int'(sram_dq_oe), 0);
            if (rd_act) begin
                rd_cnt = (rd_prev && sram_addr == rd_prev_addr) ? rd_cnt + 1 : 1;
                sram_dq_i = (rd_cnt >= int'(RD)) ? ram_rd(sram_addr) : ~ram_rd(sram_addr);
                float_cnt = TURN;
            end else begin
                rd_cnt = 0;
                sram_dq_i = 8'hEE;
                if (float_cnt > 0) float_cnt--;
            end
            rd_prev = rd_act;
            rd_prev_addr = sram_addr;
            if (wr_act) begin
                wr_cnt++;
                wr_addr = sram_addr;
                wr_data = sram_dq_o;
            end else if (wr_cnt > 0) begin
                chk(wr_cnt >= int'(WR), "R6 model write pulse width", wr_cnt, WR);
                ram[int'(wr_addr)] = wr_data;
                wr_cnt = 0;
            end
        end
    end

    // Issue one request; called at a negedge, returns at the negedge where ready is back
    task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit busy);
        logic [DW-1:0] e;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e = exp_byte(a);
        if (wr) shadow[int'(a)] = d;
        @(negedge clk);
        req_valid = busy; req_addr = ~a; req_wdata = ~d; req_write = !wr;
        if (!wr) begin
            for (int k = 1; k <= int'(RD); k++) begin
                if (k == 2) req_valid = 1'b0;
                chk(!sram_cs_n && !sram_oe_n && sram_we_n, "R3 read strobes",
                    {sram_cs_n, sram_we_n, sram_oe_n}, 3'b010);
                chk(!req_ready && !sram_dq_oe, "R2 busy during read", int'(req_ready), 0);
                chk(sram_addr == a, "R8 read address held", int'(sram_addr), int'(a));
                chk(!rsp_valid, "R4 no early response", int'(rsp_valid), 0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(rsp_valid, "R4 response pulse", int'(rsp_valid), 1);
            chk(rsp_rdata == e, "R4 read data", int'(rsp_rdata), int'(e));
            chk(sram_oe_n && sram_cs_n, "R3 read window length", int'(sram_oe_n), 1);
            for (int t = 1; t <= int'(TURN); t++) begin
                if (t > 1) begin
                    @(negedge clk);
                    chk(!rsp_valid, "R4 pulse one cycle", int'(rsp_valid), 0);
                end
                chk(!req_ready && !sram_dq_oe && sram_oe_n && sram_cs_n, "R5 turnaround float",
                    {req_ready, sram_dq_oe}, 0);
            end
            @(negedge clk);
            chk(req_ready, "R5 ready after float", int'(req_ready), 1);
        end else begin
            for (int k = 1; k <= int'(WR); k++) begin
                if (k == 2) req_valid = 1'b0;
                chk(!sram_cs_n && !sram_we_n && sram_oe_n, "R6 write strobes",
                    {sram_cs_n, sram_we_n, sram_oe_n}, 3'b001);
                chk(sram_dq_oe && sram_dq_o == d, "R7 write drive", int'(sram_dq_o), int'(d));
                chk(sram_addr == a, "R8 write address held", int'(sram_addr), int'(a));
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(sram_we_n && sram_cs_n, "R6 write pulse length", int'(sram_we_n), 1);
            chk(sram_dq_oe && sram_dq_o == d && sram_addr == a, "R8 recovery hold",
                int'(sram_dq_o), int'(d));
            chk(!req_ready, "R2 busy in recovery", int'(req_ready), 0);
            @(negedge clk);
            chk(req_ready && !sram_dq_oe, "R7 release after recovery",
                {req_ready, sram_dq_oe}, 2'b10);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid,
            "R1 state in reset", {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid,
            "R1 state after reset", int'(req_ready), 1);
        // Directed: unwritten read, write-after-read, read-after-write, busy-port requests
        op(1'b0, 15'h0123, 8'h00, 1'b0);
        op(1'b1, 15'h0123, 8'hA7, 1'b0);
        op(1'b0, 15'h0123, 8'h00, 1'b0);
        op(1'b1, 15'h7FFF, 8'hFF, 1'b1);
        op(1'b0, 15'h7FFF, 8'h00, 1'b1);
        op(1'b1, 15'h0000, 8'h00, 1'b0);
        op(1'b0, 15'h0000, 8'h00, 1'b0);
        // Random mix on a small address pool so reads revisit written bytes
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 15)) | (($urandom_range(0, 1) == 1) ? 15'h4000 : 15'h0);
            op($urandom_range(0, 1) == 1, a, 8'($urandom), $urandom_range(0, 3) == 0);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule